// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked on-chip bus and an external asynchronous static RAM of 131,072 bytes (17 address bits, 8 data bits). A client presents a one-cycle read or write request while the controller is idle. The controller then produces registered, active-low chip-select, write-strobe and output-enable signals. Each phase is held for a whole number of clock cycles, so that the memory's access time, address setup, write-strobe pulse width, data setup and output release time are all met. Each of these minimums is a parameter, counted in clock cycles and rounded up from nanoseconds by the integrator.

The shared data pins are modelled as three split signals: a drive value, a drive enable and a sampled input. The pad ring combines them. The controller turns on its drivers only during a write, and only after the memory has had time to release the pins. Writes are ended by the rising edge of the write strobe while chip select stays low. After a read, the controller waits a bus-turnaround interval before it can start another operation. Read data is captured into a register, and a single-cycle `done` marks the end of each access. Between accesses chip select is high, so the memory sits in its standby power state.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset, and whenever the block is idle, `busy` and `done` are 0, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` is 0.
- R2: A read accepted at clock edge k holds `mem_cs_n` and `mem_oe_n` at 0 and `mem_we_n` at 1 for cycles k to k+RD_CYC. `mem_dq_in` is sampled at edge k+RD_CYC+1 and appears on `rd_data` from that edge onwards.
- R3: After a read, `mem_cs_n` and `mem_oe_n` are 1 for TURN_CYC cycles, with `busy` still 1. No new request is accepted before these cycles have passed.
- R4: A write accepted at edge k holds `mem_cs_n` at 0 for cycles k to k+SETUP_CYC+PULSE_CYC+RECOV_CYC-1. `mem_we_n` is 0 for exactly cycles k+SETUP_CYC to k+SETUP_CYC+PULSE_CYC-1, and `mem_oe_n` stays 1 throughout.
- R5: `mem_dq_oe` is 1 only in a write, from cycle k+SETUP_CYC+HIZ_CYC to the end of the recovery cycles. It is never 1 while the memory may be driving the pins. It is still 1 when `mem_we_n` rises, so the data is held past the end of the write.
- R6: `mem_addr` and `mem_dq_out` do not change while `mem_cs_n` stays 0. At the rising edge of the write strobe they carry the address and data of the accepted write.
- R7: `done` is a one-cycle pulse. For a read it is in cycle k+RD_CYC+1. For a write it is in cycle k+SETUP_CYC+PULSE_CYC+RECOV_CYC, the first idle cycle.
- R8: A request presented while `busy` is 1 is ignored. The memory contents and the strobe timing of the access in progress do not change.
- R9: `busy` is 1 exactly from the acceptance edge until the block returns to idle. A request presented in the cycle where `busy` has just dropped is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read data |
| mem_addr | output | 17 | Address to the memory |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Data sampled from the memory pins |

## Verification
Every strobe is a flop loaded from the next state, so each one changes at the acceptance edge k plus a fixed number of phase cycles. Read data and `done` arrive RD_CYC+1 cycles after acceptance for a read, and SETUP_CYC+PULSE_CYC+RECOV_CYC cycles after acceptance for a write. The bench records k for each accepted request. Two nanoseconds after every clock edge it computes the expected level of every strobe, `busy` and `done` from the offset since k, and compares them. The memory model checks the nanosecond timing of each write at the rising edge of the write strobe, and checks for bus contention on every cycle.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURNAROUND
  } ctrl_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic             tick_en;

  always_comb begin
    if (load)               cnt_nxt = load_val;
    else if (cnt_q != '0)   cnt_nxt = cnt_q - CNT_W'(1);
    else                    cnt_nxt = cnt_q;
  end

  assign tick_en = load || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_nxt;
  end

  assign cnt     = cnt_q;
  assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_ctrl_pkg::*;
#(
  parameter int CNT_W     = 2,
  parameter int RD_CYC    = 2,
  parameter int TURN_CYC  = 1,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int RECOV_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output ctrl_state_e      state,
  output ctrl_state_e      state_nxt,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  ctrl_state_e state_q;

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE:       if (req_valid) state_nxt = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
      ST_RD_ACCESS:  if (expired)   state_nxt = ST_RD_CAPTURE;
      ST_RD_CAPTURE:                state_nxt = ST_TURNAROUND;
      ST_TURNAROUND: if (expired)   state_nxt = ST_IDLE;
      ST_WR_SETUP:   if (expired)   state_nxt = ST_WR_PULSE;
      ST_WR_PULSE:   if (expired)   state_nxt = ST_WR_RECOVER;
      ST_WR_RECOVER: if (expired)   state_nxt = ST_IDLE;
      default:                      state_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_nxt)
      ST_RD_ACCESS:  tmr_val = CNT_W'(RD_CYC - 1);
      ST_TURNAROUND: tmr_val = CNT_W'(TURN_CYC - 1);
      ST_WR_SETUP:   tmr_val = CNT_W'(SETUP_CYC - 1);
      ST_WR_PULSE:   tmr_val = CNT_W'(PULSE_CYC - 1);
      ST_WR_RECOVER: tmr_val = CNT_W'(RECOV_CYC - 1);
      default:       tmr_val = '0;
    endcase
  end

  assign tmr_load = (state_nxt != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nxt;
  end

  assign state = state_q;

endmodule

// File: rtl/asram_io_regs.sv
module asram_io_regs
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2,
  parameter int DRV_AT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_state_e       state,
  input  ctrl_state_e       state_nxt,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);

  localparam logic [CNT_W-1:0] DRV_LIMIT = CNT_W'(DRV_AT);

  logic accept, capture_en;
  logic cs_n_d, we_n_d, oe_n_d, dq_oe_d, done_d;

  assign accept     = (state == ST_IDLE) && req_valid;
  assign capture_en = (state == ST_RD_CAPTURE);

  always_comb begin
    cs_n_d  = (state_nxt == ST_IDLE) || (state_nxt == ST_TURNAROUND);
    oe_n_d  = !((state_nxt == ST_RD_ACCESS) || (state_nxt == ST_RD_CAPTURE));
    we_n_d  = (state_nxt != ST_WR_PULSE);
    dq_oe_d = ((state_nxt == ST_WR_PULSE) && (cnt_nxt <= DRV_LIMIT)) ||
              (state_nxt == ST_WR_RECOVER);
    done_d  = capture_en || ((state == ST_WR_RECOVER) && (state_nxt == ST_IDLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      done      <= 1'b0;
    end else begin
      mem_cs_n  <= cs_n_d;
      mem_we_n  <= we_n_d;
      mem_oe_n  <= oe_n_d;
      mem_dq_oe <= dq_oe_d;
      done      <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_data <= '0;
    else if (capture_en) rd_data <= mem_dq_in;
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int RD_CYC    = 2,
  parameter int TURN_CYC  = 1,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HIZ_CYC   = 1,
  parameter int RECOV_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned MAX_CYC = max2(max2(max2(RD_CYC, TURN_CYC), max2(SETUP_CYC, PULSE_CYC)),
                                         RECOV_CYC);
  localparam int CNT_W  = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam int DRV_AT = PULSE_CYC - 1 - HIZ_CYC;

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  ctrl_state_e      state, state_nxt;
  logic             tmr_load, expired;
  logic [CNT_W-1:0] tmr_val, cnt, cnt_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  asram_ctrl_fsm #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC),
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .req_write(req_write),
    .expired(expired), .state(state), .state_nxt(state_nxt),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .load(tmr_load), .load_val(tmr_val),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .expired(expired)
  );

  asram_io_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DRV_AT(DRV_AT)
  ) u_io (
    .clk(clk), .rst_n(rst_int_n), .state(state), .state_nxt(state_nxt),
    .cnt_nxt(cnt_nxt), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_dq_in(mem_dq_in), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .rd_data(rd_data), .done(done)
  );

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int HIZ_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  // R1: idle means deselected with the bus released
  p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R2: output enable only in a selected read
  p_oe_read_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n));

  // R4: write strobe only under chip select
  p_we_under_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  // R5: controller drives only when the memory output is off
  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_cs_n));

  // R5: drive starts only after the write strobe has been low for a cycle
  p_drive_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_dq_oe) && (HIZ_CYC > 0)) |-> (!mem_we_n && $past(!mem_we_n)));

  // R5: data still driven when the write strobe rises
  p_hold_at_we_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && !mem_cs_n) |-> mem_dq_oe);

  // R6: address stable under chip select
  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  // R6: driven data stable
  p_wdata_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HIZ_CYC(HIZ_CYC)
) u_asram_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_addr(mem_addr),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

  localparam int RD   = 2;
  localparam int TURN = 1;
  localparam int SU   = 1;
  localparam int PW   = 2;
  localparam int HZ   = 1;
  localparam int RC   = 1;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        busy, done;
  logic [7:0]  rd_data;
  logic [16:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  asram_ctrl #(
    .RD_CYC(RD), .TURN_CYC(TURN), .SETUP_CYC(SU), .PULSE_CYC(PW),
    .HIZ_CYC(HZ), .RECOV_CYC(RC)
  ) u_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit chk_en = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // ---------------- behavioural memory with timing checks ----------------
  logic [7:0] model_mem [int];
  logic [7:0] model_dq;
  logic       mem_drive;
  realtime    t_we_fall, t_data, t_addr, t_release;

  assign mem_drive = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq_in = model_dq;

  function automatic logic [7:0] mem_rd(input logic [16:0] a);
    if (model_mem.exists(int'(a))) return model_mem[int'(a)];
    return 8'h00;
  endfunction

  always @(mem_drive or mem_addr) model_dq = mem_drive ? mem_rd(mem_addr) : 8'h00;

  initial begin
    t_we_fall = 0.0; t_data = 0.0; t_addr = 0.0; t_release = 0.0;
  end
  always @(negedge mem_we_n) t_we_fall = $realtime;
  always @(mem_dq_out)       t_data    = $realtime;
  always @(negedge mem_drive) t_release = $realtime;

  always @(mem_addr) begin
    t_addr = $realtime;
    if (chk_en && !mem_cs_n && !mem_we_n)
      check(1'b0, "R6 address moved during write", 32'(mem_addr), 32'(0));
  end

  always @(posedge mem_dq_oe) begin
    t_data = $realtime;
    if (chk_en)
      check(!mem_drive && ($realtime - t_release >= 4.0), "R5 drive before memory release",
            32'($rtoi($realtime - t_release)), 32'(4));
  end

  // ---------------- reference record ----------------
  bit          op_valid = 0;
  bit          op_wr;
  int          op_acc;
  logic [16:0] op_addr;
  logic [7:0]  op_data;
  logic [7:0]  sb [int];

  always @(posedge mem_we_n) begin
    if (chk_en && !mem_cs_n) begin
      check($realtime - t_we_fall >= 6.0, "R4 write pulse width",
            32'($rtoi($realtime - t_we_fall)), 32'(6));
      check(mem_dq_oe && ($realtime - t_data >= 5.0), "R5 data setup to write end",
            32'($rtoi($realtime - t_data)), 32'(5));
      check($realtime - t_addr >= 7.0, "R6 address setup to write end",
            32'($rtoi($realtime - t_addr)), 32'(7));
      check(mem_addr == op_addr, "R6 write address", 32'(mem_addr), 32'(op_addr));
      check(mem_dq_out == op_data, "R6 write data", 32'(mem_dq_out), 32'(op_data));
      model_mem[int'(mem_addr)] = mem_dq_out;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // cycle-by-cycle comparison, 2 ns after each edge
  always @(posedge clk) begin
    #2;
    if (chk_en) begin
      int  rel;
      bit  e_busy, e_cs, e_oe, e_we, e_dq, e_done;
      string tg_cs, tg_busy;
      rel = op_valid ? (cyc - op_acc) : -1;
      e_busy = 0; e_cs = 0; e_oe = 0; e_we = 0; e_dq = 0; e_done = 0;
      tg_cs = "R1 idle strobes"; tg_busy = "R1 idle busy";
      if (rel >= 0 && !op_wr) begin
        e_busy = (rel <= RD + TURN);
        e_cs   = (rel <= RD);
        e_oe   = (rel <= RD);
        e_done = (rel == RD + 1);
        if (rel <= RD) begin tg_cs = "R2 read strobes"; tg_busy = "R9 read busy"; end
        else if (rel <= RD + TURN) begin tg_cs = "R3 turnaround strobes"; tg_busy = "R3 turnaround busy"; end
      end else if (rel >= 0 && op_wr) begin
        e_busy = (rel <= SU + PW + RC - 1);
        e_cs   = e_busy;
        e_we   = (rel >= SU) && (rel <= SU + PW - 1);
        e_dq   = (rel >= SU + HZ) && (rel <= SU + PW + RC - 1);
        e_done = (rel == SU + PW + RC);
        if (e_busy) begin tg_cs = "R4 write strobes"; tg_busy = "R9 write busy"; end
      end
      check(busy == e_busy, tg_busy, 32'(busy), 32'(e_busy));
      check(mem_cs_n == !e_cs, tg_cs, 32'(mem_cs_n), 32'(!e_cs));
      check(mem_oe_n == !e_oe, tg_cs, 32'(mem_oe_n), 32'(!e_oe));
      check(mem_we_n == !e_we, "R4 write strobe window", 32'(mem_we_n), 32'(!e_we));
      check(mem_dq_oe == e_dq, "R5 drive window", 32'(mem_dq_oe), 32'(e_dq));
      check(done == e_done, "R7 done timing", 32'(done), 32'(e_done));
      check(!(mem_drive && mem_dq_oe), "R5 bus contention", 32'(mem_dq_oe), 32'(0));
      if (e_done && !op_wr)
        check(rd_data == op_data, "R2 read data", 32'(rd_data), 32'(op_data));
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    op_wr = wr; op_addr = a; op_acc = cyc + 1; op_valid = 1;
    if (wr) begin
      op_data = d;
      sb[int'(a)] = d;
    end else begin
      op_data = sb.exists(int'(a)) ? sb[int'(a)] : 8'h00;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || done) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rng;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 reset busy", 32'(busy), 32'(0));
    check(done == 1'b0, "R1 reset done", 32'(done), 32'(0));
    check(mem_cs_n && mem_we_n && mem_oe_n, "R1 reset strobes",
          32'({mem_cs_n, mem_we_n, mem_oe_n}), 32'(7));
    check(mem_dq_oe == 1'b0, "R1 reset bus released", 32'(mem_dq_oe), 32'(0));
    chk_en = 1;

    // writes at boundaries, then reads (R2, R4, R9 back-to-back)
    issue(1, 17'h00000, 8'h3C);
    issue(1, 17'h1FFFF, 8'hC3);
    issue(1, 17'h0AAAA, 8'h55);
    issue(0, 17'h00000, 8'h00);
    issue(0, 17'h1FFFF, 8'h00);
    issue(0, 17'h0AAAA, 8'h00);
    // read immediately followed by write (R3 turnaround), then read it back
    issue(1, 17'h15555, 8'hAA);
    issue(0, 17'h15555, 8'h00);
    issue(0, 17'h00001, 8'h00);

    // R8: write presented while a read is in progress must be ignored
    wait_idle();
    issue(0, 17'h0AAAA, 8'h00);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h0AAAA; req_wdata = 8'hFF;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    issue(0, 17'h0AAAA, 8'h00);
    wait_idle();
    check(rd_data == 8'h55, "R8 ignored write left memory unchanged", 32'(rd_data), 32'h55);

    // mixed traffic
    rng = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      issue(rng[0], {14'h0, rng[3:1]} | {rng[20:19], 15'h0}, rng[15:8]);
    end
    wait_idle();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R9 actual=%0h expected=%0h", busy, 0);
    summary();
    $finish;
  end

endmodule